// File: doc/BRIEF.md
# Rank-Counter LRU Replacement Unit

This unit keeps least-recently-used order for every set of an N-way set-associative cache. Each way of each set holds a small recency rank. Rank 0 is the most recently used way and rank NUM_WAYS-1 is the least recently used way. The ranks of one set always form a permutation of 0 to NUM_WAYS-1. The unit stores no tags or data.

The surrounding cache presents an access strobe with a set index. It also presents a hit flag and, on a hit, the way that matched. The unit drives, without a register, the least recently used way of the addressed set. On a miss it flags that way as the one to refill. On the clock edge of a valid access, the unit rewrites the ranks of that set. A hit moves the touched way to the front and ages only the ways that were more recent than it. A miss refills the least recently used way, makes it rank 0 and ages every other way of the set.

Top module: `lru_rank_unit`

## Requirements
- R1: After reset, way w of every set holds rank w, so every set reports way NUM_WAYS-1 as its victim.
- R2: Within each set the ranks always form a permutation of 0 to NUM_WAYS-1.
- R3: On a valid hit, the hit way's rank becomes 0. Every way whose rank was lower than the hit way's old rank gains one. Ways with a higher rank keep their rank.
- R4: `victim_way` is always the way of set `acc_set` whose rank is NUM_WAYS-1. `victim_valid` is 1 exactly when `acc_valid`=1 and `acc_hit`=0.
- R5: On a valid miss, the victim way's rank becomes 0 and every other way of the set gains one.
- R6: `victim_way` follows the current ranks of the addressed set with no register in between. Rank changes appear after the clock edge of the access, and only the addressed set changes.
- R7: While `acc_valid`=0, no rank changes, whatever `acc_hit`, `acc_way` and `acc_set` carry.
- R8: With NUM_WAYS=1, `victim_way` is always 0 and the unit holds no rank storage.
- R9: With four ways and the reference sequence A B C D D D B D E into one set, starting from reset, E replaces the way that A was filled into. Afterwards D, B, C and E hold ranks 1, 2, 3 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe; ranks update on this cycle's clock edge |
| acc_set | input | SET_W | Set index of the access |
| acc_hit | input | 1 | 1 = hit, 0 = miss |
| acc_way | input | WAY_W | Way that hit (used only when acc_hit=1) |
| victim_way | output | WAY_W | Least recently used way of set acc_set |
| victim_valid | output | 1 | Miss in progress: victim_way is to be refilled |

## Verification
The main function runs first on the nine-reference sequence, which mixes misses, repeated hits on the front way and hits on middle ranks. This sequence separates ageing every way from ageing only the more recent ways. A hit on the least recently used way then checks that every other way ages. A hit on rank 0 checks that nothing else changes. Long pseudo-random mixes across all sets, compared with a rank model, show whether updates leak into other sets. Idle cycles with noisy inputs show whether updates happen without the strobe. A one-way instance covers the degenerate victim.

// File: rtl/lru_rank_pkg.sv
// Shared types and helpers for the rank-counter LRU unit.
package lru_rank_pkg;

    // Kind of rank update applied to the addressed set.
    typedef enum logic [1:0] {
        UPD_IDLE = 2'd0,
        UPD_HIT  = 2'd1,
        UPD_MISS = 2'd2
    } upd_kind_e;

    // Index width that never collapses to zero bits.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lru_rank_store.sv
// Rank storage: one register group per set. Each group holds NUM_WAYS
// ranks of RANK_W bits. Assumes NUM_WAYS is a power of two, so that
// ranks 0..NUM_WAYS-1 fill RANK_W exactly. Reset loads rank w into way w.
module lru_rank_store #(
    parameter int NUM_WAYS = 4,
    parameter int NUM_SETS = 8,
    parameter int RANK_W   = 2,
    parameter int SET_W    = 3,
    localparam int GRP_W   = NUM_WAYS * RANK_W,
    localparam int BUS_W   = NUM_SETS * GRP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [GRP_W-1:0] wr_ranks,
    output logic [BUS_W-1:0] rank_bus
);

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        logic [GRP_W-1:0] grp_q;

        // Load the reset permutation, or take new ranks when this set is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int w = 0; w < NUM_WAYS; w++) begin
                    grp_q[w*RANK_W +: RANK_W] <= RANK_W'(w);
                end
            end else if (wr_en && (wr_set == SET_W'(s))) begin
                grp_q <= wr_ranks;
            end
        end

        assign rank_bus[s*GRP_W +: GRP_W] = grp_q;
    end

endmodule

// File: rtl/lru_victim_find.sv
// Finds the way whose rank equals NUM_WAYS-1 within one set.
// Assumes the ranks form a permutation, so exactly one way matches.
module lru_victim_find #(
    parameter int NUM_WAYS = 4,
    parameter int RANK_W   = 2,
    parameter int WAY_W    = 2,
    localparam int GRP_W   = NUM_WAYS * RANK_W
) (
    input  logic [GRP_W-1:0] ranks,
    output logic [WAY_W-1:0] lru_way
);

    // Scan the ways for the largest rank value.
    always_comb begin
        lru_way = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (ranks[w*RANK_W +: RANK_W] == RANK_W'(NUM_WAYS - 1)) begin
                lru_way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/lru_rank_next.sv
// Computes the next ranks of one set from its current ranks, the update
// kind and the touched way (the hit way, or the victim on a miss).
// Assumes the current ranks form a permutation.
module lru_rank_next
    import lru_rank_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int RANK_W   = 2,
    parameter int WAY_W    = 2,
    localparam int GRP_W   = NUM_WAYS * RANK_W
) (
    input  logic [GRP_W-1:0] cur_ranks,
    input  upd_kind_e        kind,
    input  logic [WAY_W-1:0] touch_way,
    output logic [GRP_W-1:0] nxt_ranks
);

    logic [RANK_W-1:0] touch_rank;

    // Rank that the touched way holds before the update.
    always_comb begin
        touch_rank = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (touch_way == WAY_W'(w)) touch_rank = cur_ranks[w*RANK_W +: RANK_W];
        end
    end

    // Apply the hit or miss ageing rule to every way.
    always_comb begin
        for (int w = 0; w < NUM_WAYS; w++) begin
            logic [RANK_W-1:0] r;
            r = cur_ranks[w*RANK_W +: RANK_W];
            unique case (kind)
                UPD_HIT: begin
                    if (touch_way == WAY_W'(w))  nxt_ranks[w*RANK_W +: RANK_W] = '0;
                    else if (r < touch_rank)     nxt_ranks[w*RANK_W +: RANK_W] = r + 1'b1;
                    else                         nxt_ranks[w*RANK_W +: RANK_W] = r;
                end
                UPD_MISS: begin
                    if (touch_way == WAY_W'(w))  nxt_ranks[w*RANK_W +: RANK_W] = '0;
                    else                         nxt_ranks[w*RANK_W +: RANK_W] = r + 1'b1;
                end
                default:                         nxt_ranks[w*RANK_W +: RANK_W] = r;
            endcase
        end
    end

endmodule

// File: rtl/lru_rank_unit.sv
// Top of the rank-counter LRU replacement unit. It selects the ranks of
// the addressed set, reports that set's least recently used way without
// a register, and writes the aged ranks back on the edge of a valid
// access. Assumes NUM_WAYS is a power of two. NUM_WAYS=1 builds no storage.
module lru_rank_unit
    import lru_rank_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int NUM_SETS = 8,
    localparam int WAY_W   = idx_width(NUM_WAYS),
    localparam int SET_W   = idx_width(NUM_SETS),
    localparam int RANK_W  = WAY_W,
    localparam int GRP_W   = NUM_WAYS * RANK_W,
    localparam int BUS_W   = NUM_SETS * GRP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic             acc_hit,
    input  logic [WAY_W-1:0] acc_way,
    output logic [WAY_W-1:0] victim_way,
    output logic             victim_valid
);

    logic [BUS_W-1:0] rank_bus;

    // A miss is in progress when the strobe is up and there is no hit.
    assign victim_valid = acc_valid && !acc_hit;

    if (NUM_WAYS == 1) begin : g_direct
        assign victim_way = '0;
        assign rank_bus   = '0;
    end else begin : g_assoc
        logic [GRP_W-1:0] cur_ranks;
        logic [GRP_W-1:0] nxt_ranks;
        logic [WAY_W-1:0] touch_way;
        upd_kind_e        kind;

        // Select the rank group of the addressed set.
        always_comb begin
            cur_ranks = rank_bus[GRP_W-1:0];
            for (int s = 0; s < NUM_SETS; s++) begin
                if (acc_set == SET_W'(s)) cur_ranks = rank_bus[s*GRP_W +: GRP_W];
            end
        end

        // Classify the access and pick the way it touches.
        always_comb begin
            if (!acc_valid)   kind = UPD_IDLE;
            else if (acc_hit) kind = UPD_HIT;
            else              kind = UPD_MISS;
            touch_way = acc_hit ? acc_way : victim_way;
        end

        lru_victim_find #(
            .NUM_WAYS (NUM_WAYS),
            .RANK_W   (RANK_W),
            .WAY_W    (WAY_W)
        ) find_i (
            .ranks    (cur_ranks),
            .lru_way  (victim_way)
        );

        lru_rank_next #(
            .NUM_WAYS (NUM_WAYS),
            .RANK_W   (RANK_W),
            .WAY_W    (WAY_W)
        ) next_i (
            .cur_ranks (cur_ranks),
            .kind      (kind),
            .touch_way (touch_way),
            .nxt_ranks (nxt_ranks)
        );

        lru_rank_store #(
            .NUM_WAYS (NUM_WAYS),
            .NUM_SETS (NUM_SETS),
            .RANK_W   (RANK_W),
            .SET_W    (SET_W)
        ) store_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (acc_valid),
            .wr_set   (acc_set),
            .wr_ranks (nxt_ranks),
            .rank_bus (rank_bus)
        );
    end

endmodule

// File: rtl/lru_rank_chk.sv
// Property checker for lru_rank_unit, attached by bind. It watches the
// ports and the internal rank bus. It assumes a synchronous active-low reset.
module lru_rank_chk #(
    parameter int NUM_WAYS = 4,
    parameter int NUM_SETS = 8,
    parameter int WAY_W    = 2,
    parameter int SET_W    = 3,
    parameter int RANK_W   = 2,
    localparam int BUS_W   = NUM_SETS * NUM_WAYS * RANK_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic [SET_W-1:0] acc_set,
    input logic             acc_hit,
    input logic [WAY_W-1:0] acc_way,
    input logic [WAY_W-1:0] victim_way,
    input logic             victim_valid,
    input logic [BUS_W-1:0] rank_bus
);

    function automatic logic [RANK_W-1:0] rk(input logic [BUS_W-1:0] b,
                                             input int s, input int w);
        return b[(s*NUM_WAYS + w)*RANK_W +: RANK_W];
    endfunction

    logic perm_ok;

    // Every set must hold each rank value exactly once.
    always_comb begin
        perm_ok = 1'b1;
        for (int s = 0; s < NUM_SETS; s++) begin
            logic [(1<<RANK_W)-1:0] seen;
            seen = '0;
            for (int w = 0; w < NUM_WAYS; w++) seen[rk(rank_bus, s, w)] = 1'b1;
            if ($countones(seen) != NUM_WAYS) perm_ok = 1'b0;
        end
    end

    a_r2_permutation: assert property (@(posedge clk) disable iff (!rst_n)
        perm_ok);

    a_r3_hit_to_front: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_hit) |=>
        rk(rank_bus, int'($past(acc_set)), int'($past(acc_way))) == '0);

    a_r4_victim_is_lru: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> rk(rank_bus, int'(acc_set), int'(victim_way)) == RANK_W'(NUM_WAYS - 1));

    a_r5_fill_to_front: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |=>
        rk(rank_bus, int'($past(acc_set)), int'($past(victim_way))) == '0);

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(rank_bus));

endmodule

bind lru_rank_unit lru_rank_chk #(
    .NUM_WAYS (NUM_WAYS),
    .NUM_SETS (NUM_SETS),
    .WAY_W    (WAY_W),
    .SET_W    (SET_W),
    .RANK_W   (RANK_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_set      (acc_set),
    .acc_hit      (acc_hit),
    .acc_way      (acc_way),
    .victim_way   (victim_way),
    .victim_valid (victim_valid),
    .rank_bus     (rank_bus)
);

// File: tb/lru_rank_unit_tb_top.sv
// Self-checking bench for lru_rank_unit: a trace table, directed corner
// cases and a model-checked pseudo-random mix.
module lru_rank_unit_tb_top;

    localparam int WAYS = 4;
    localparam int SETS = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic [2:0] acc_set = '0;
    logic       acc_hit = 1'b0;
    logic [1:0] acc_way = '0;
    logic [1:0] victim_way;
    logic       victim_valid;

    logic       d1_valid = 1'b0;
    logic       d1_set = 1'b0;
    logic       d1_hit = 1'b0;
    logic       d1_way = 1'b0;
    logic       d1_victim;
    logic       d1_vvalid;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    int model [SETS][WAYS];

    always #10 clk = ~clk;

    lru_rank_unit #(.NUM_WAYS(WAYS), .NUM_SETS(SETS)) dut_i (
        .clk (clk), .rst_n (rst_n), .acc_valid (acc_valid), .acc_set (acc_set),
        .acc_hit (acc_hit), .acc_way (acc_way),
        .victim_way (victim_way), .victim_valid (victim_valid));

    lru_rank_unit #(.NUM_WAYS(1), .NUM_SETS(2)) dut1_i (
        .clk (clk), .rst_n (rst_n), .acc_valid (d1_valid), .acc_set (d1_set),
        .acc_hit (d1_hit), .acc_way (d1_way),
        .victim_way (d1_victim), .victim_valid (d1_vvalid));

    // Trace A B C D D D B D E then a hit on E, all in set 2: {hit, way, expected victim}.
    localparam logic [4:0] TRACE [10] = '{
        {1'b0, 2'd0, 2'd3}, {1'b0, 2'd0, 2'd2}, {1'b0, 2'd0, 2'd1}, {1'b0, 2'd0, 2'd0},
        {1'b1, 2'd0, 2'd3}, {1'b1, 2'd0, 2'd3}, {1'b1, 2'd2, 2'd3}, {1'b1, 2'd0, 2'd3},
        {1'b0, 2'd0, 2'd3}, {1'b1, 2'd3, 2'd1}
    };

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model_lru(input int s);
        int v = 0;
        for (int w = 0; w < WAYS; w++) if (model[s][w] == WAYS - 1) v = w;
        return v;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) model[s][w] = w;
    endtask

    // Apply the rank rules to the model, as the requirements state them.
    task automatic model_update(input int s, input bit hit, input int way);
        int t = hit ? way : model_lru(s);
        int tr = model[s][t];
        for (int w = 0; w < WAYS; w++) begin
            if (w == t) model[s][w] = 0;
            else if (!hit || model[s][w] < tr) model[s][w] = model[s][w] + 1;
        end
    endtask

    // One access: drive after the falling edge, check the victim, commit on the rising edge.
    task automatic access(input int s, input bit hit, input int way, input string req);
        @(negedge clk);
        acc_valid = 1'b1; acc_set = 3'(s); acc_hit = hit; acc_way = 2'(way);
        #5;
        check(req, int'(victim_way), model_lru(s));
        check("R4 valid", int'(victim_valid), int'(!hit));
        @(posedge clk);
        model_update(s, hit, way);
        #1;
        acc_valid = 1'b0;
    endtask

    task automatic probe(input int s, input int exp, input string req);
        @(negedge clk);
        acc_valid = 1'b0; acc_set = 3'(s);
        #5;
        check(req, int'(victim_way), exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int seed = 32'h1234_5678;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset ranks, so every set points at way 3.
        probe(0, 3, "R1 set0");
        probe(7, 3, "R1 set7");

        // R9/R3/R5/R6: trace table in set 2.
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            acc_valid = 1'b1; acc_set = 3'd2;
            acc_hit = TRACE[i][4]; acc_way = TRACE[i][3:2];
            #5;
            check($sformatf("R9 step %0d", i), int'(victim_way), int'(TRACE[i][1:0]));
            @(posedge clk);
            model_update(2, TRACE[i][4], int'(TRACE[i][3:2]));
            #1 acc_valid = 1'b0;
        end
        // After the trace: C (way1) is LRU; an untouched set is still at reset.
        probe(2, 1, "R9 final lru");
        probe(5, 3, "R6 other set untouched");

        // R7: noisy idle inputs leave set 2 unchanged.
        @(negedge clk);
        acc_valid = 1'b0; acc_set = 3'd2; acc_hit = 1'b1; acc_way = 2'd1;
        repeat (3) @(posedge clk);
        @(negedge clk); acc_hit = 1'b0;
        @(posedge clk);
        probe(2, 1, "R7 idle hold");
        check("R4 no valid when idle", int'(victim_valid), 0);

        // R3: hit on the LRU way (way1) ages all others: ranks 2,0,3,1 -> LRU way2.
        access(2, 1'b1, 1, "R3 hit lru");
        probe(2, 2, "R3 all aged");
        // R3: hit on front way changes nothing.
        access(2, 1'b1, 1, "R3 hit front");
        probe(2, 2, "R3 front hit no change");

        // R2/R5/R6: pseudo-random mix over all sets against the model.
        for (int i = 0; i < 400; i++) begin
            seed = seed * 1103515245 + 12345;
            access((seed >>> 8) & 7, ((seed >>> 16) & 3) != 0, (seed >>> 20) & 3, "R5 R6 mix");
        end

        // R1: reset in mid-run restores the permutation.
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        model_reset();
        probe(2, 3, "R1 re-reset");

        // R8: one-way instance always reports way 0.
        @(negedge clk);
        d1_valid = 1'b1; d1_set = 1'b1; d1_hit = 1'b0;
        #5;
        check("R8 victim", int'(d1_victim), 0);
        check("R8 valid", int'(d1_vvalid), 1);
        @(negedge clk);
        d1_hit = 1'b1;
        #5;
        check("R8 hit victim", int'(d1_victim), 0);
        @(negedge clk); d1_valid = 1'b0;

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule